// File: doc/BRIEF.md
# Clock Generator Configuration Port (Two-Wire Block Slave)

This block is the serial configuration port of a clock generator. It watches a two-wire I2C bus (SCL, SDA) with a much faster system clock, spots start and stop conditions, answers to one fixed device address, and keeps six 8-bit configuration registers. The clock control logic reads these registers on a parallel output bus. Register 0 holds the function and frequency select bits. The other five registers are output-enable masks: a 1 turns the matching clock output on and a 0 turns it off.

The protocol is a cut-down block transfer. A write carries a command byte and a count byte that the slave acknowledges and throws away. The data bytes that follow fill the registers in rising order from register 0. A read returns a count byte first and then every register in order. The block never drives SDA high. It only pulls the line low, for acknowledges and for zero bits of read data. Standard-mode bit rates (100 kbit/s and below) are the target, and the system clock is many times faster than SCL.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged: the slave pulls SDA low during the ninth clock.
- R2: In a write, the first two bytes after the address are acknowledged and their values never reach any register.
- R3: Write data bytes go to registers 0, 1, 2, … in arrival order. cfg_regs[8*k+7:8*k] is register k, and bit 7 of each byte is the first one on the wire.
- R4: A stop after any complete data byte keeps every byte already received. Registers that were not reached keep their earlier values.
- R5: Any other address byte is not acknowledged (SDA stays released), and the slave ignores the bus until the next start.
- R6: A read returns the byte 0x06 and then registers 0 to 5 in order, as long as the host acknowledges each byte.
- R7: After reset, register 0 is 0x0C (bits 3 and 2 set, the others clear) and registers 1 to 5 are 0xFF.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing more until a stop or a new start.
- R9: Write data bytes after the sixth are acknowledged and discarded.
- R10: SDA falling while SCL is high is a start: it aborts any transfer and begins a new address byte. SDA rising while SCL is high is a stop: it returns the slave to idle.
- R11: The SDA pull-down changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_regs | output | 8*NUM_REGS | Configuration registers, register k in bits 8k+7..8k |

## Verification
The bench runs a full six-byte write with non-zero command and count bytes. These tell stored data apart from the discarded header. It also runs a two-byte write cut short by a stop, which separates committed bytes from bytes that were never reached, and an eight-byte write, which shows that overflow bytes are dropped. A foreign address followed by a data byte checks both the NACK and the idle state that follows. Reads are tried once to the end and once with an early host NACK and a repeated start into a write; these separate a correct release of SDA from a slave that keeps driving.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
  } bus_state_t;

  // Reset value of configuration register idx
  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 0) ? 8'h0C : 8'hFF;
  endfunction
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw, lvl, prev;
  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= lvl;
  end

  assign scl_lvl   = lvl[1];
  assign sda_lvl   = lvl[0];
  assign scl_rise  = lvl[1] & ~prev[1];
  assign scl_fall  = ~lvl[1] & prev[1];
  assign start_det = lvl[1] & prev[1] & prev[0] & ~lvl[0];
  assign stop_det  = lvl[1] & prev[1] & ~prev[0] & lvl[0];
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [7:0]               wr_data,
  output logic [NUM_REGS-1:0][7:0] regs
);
  import clkcfg_pkg::*;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= reg_default(i);
      else if (wr_en && (int'(wr_idx) == i))
        regs[i] <= wr_data;
    end
  end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int         NUM_REGS    = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_drive_low,
  output logic [NUM_REGS*8-1:0] cfg_regs
);
  import clkcfg_pkg::*;

  localparam int HDR_BYTES = 2;
  localparam int IDX_W     = $clog2(NUM_REGS + HDR_BYTES + 1);
  localparam int IDX_MAX   = NUM_REGS + HDR_BYTES;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  bus_state_t               state;
  logic [3:0]               bitcnt;
  logic [7:0]               shreg, tx;
  logic [IDX_W-1:0]         byte_idx;
  logic                     rw, drive, host_ack;
  logic                     wr_en;
  logic [IDX_W-1:0]         wr_idx;
  logic [7:0]               rd_byte;
  logic [NUM_REGS-1:0][7:0] regs;

  clkcfg_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(shreg), .regs(regs)
  );

  // Data bytes past the header and inside the register range are stored
  assign wr_idx = byte_idx - IDX_W'(HDR_BYTES);
  assign wr_en  = (state == ST_WDATA) && scl_fall && (bitcnt == 4'd8) &&
                  (int'(byte_idx) >= HDR_BYTES) &&
                  (int'(byte_idx) < HDR_BYTES + NUM_REGS);

  // Read stream: count byte, then registers, then released bus
  always_comb begin
    rd_byte = 8'hFF;
    if (byte_idx == '0) rd_byte = 8'(NUM_REGS);
    else
      for (int i = 0; i < NUM_REGS; i++)
        if (int'(byte_idx) == i + 1) rd_byte = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx       <= '0;
      byte_idx <= '0;
      rw       <= 1'b0;
      drive    <= 1'b0;
      host_ack <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      byte_idx <= '0;
      drive    <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      drive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                rw    <= shreg[0];
                drive <= 1'b1;
                state <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              drive <= 1'b1;
              state <= ST_ACK;
              if (int'(byte_idx) < IDX_MAX) byte_idx <= byte_idx + IDX_W'(1);
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              tx     <= rd_byte;
              drive  <= ~rd_byte[7];
              bitcnt <= 4'd1;
              state  <= ST_RDATA;
              if (int'(byte_idx) < IDX_MAX) byte_idx <= byte_idx + IDX_W'(1);
            end else begin
              drive  <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              drive    <= 1'b0;
              host_ack <= 1'b0;
              state    <= ST_RACK;
            end else begin
              drive  <= ~tx[6];
              tx     <= {tx[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) host_ack <= ~sda_lvl;
          else if (scl_fall) begin
            if (host_ack) begin
              tx     <= rd_byte;
              drive  <= ~rd_byte[7];
              bitcnt <= 4'd1;
              state  <= ST_RDATA;
              if (int'(byte_idx) < IDX_MAX) byte_idx <= byte_idx + IDX_W'(1);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_drive_low = drive;
  assign cfg_regs      = regs;
endmodule

// File: rtl/clkcfg_i2c_chk.sv
module clkcfg_i2c_chk #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       scl_lvl,
  input logic                       start_det,
  input logic                       stop_det,
  input logic                       sda_drive_low,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [NUM_REGS*8-1:0]      cfg_regs,
  input clkcfg_pkg::bus_state_t     state
);
  import clkcfg_pkg::*;

  // R10
  start_enters_addr_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR));

  // R10
  stop_goes_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_drive_low));

  // R11
  drive_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_low) |-> !scl_lvl);

  // R9
  write_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < NUM_REGS));

  // R4
  regs_change_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_regs) |-> $past(wr_en));

  // R8
  drive_only_when_owner_chk: assert property (@(posedge clk) disable iff (rst)
    sda_drive_low |-> (state == ST_ACK || state == ST_RDATA));
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .sda_drive_low(sda_drive_low), .wr_en(wr_en),
  .wr_idx(wr_idx), .cfg_regs(cfg_regs), .state(state)
);

// File: tb/test_clkcfg_i2c_slave.sv
module test_clkcfg_i2c_slave;
  localparam int N = 6;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_host = 1'b1;
  logic sda_drive_low;
  logic [N*8-1:0] cfg_regs;
  wire  sda_line = sda_host & ~sda_drive_low;

  always #2 clk = ~clk;

  clkcfg_i2c_slave i_clkcfg_i2c_slave (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .cfg_regs(cfg_regs)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] model [N];
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read bytes as they come out
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      automatic logic [7:0] a = act_q.pop_front();
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(a == e, t, a, e);
    end
  end

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_host = 1'b1; qwait(); scl = 1'b1; qwait();
    sda_host = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_host = 1'b0; qwait(); scl = 1'b1; qwait(); sda_host = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_host = b[i]; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    end
    sda_host = 1'b1; qwait(); scl = 1'b1; qwait();
    ack = ~sda_line;
    qwait(); scl = 1'b0; qwait();
  endtask

  task automatic recv_byte(input logic give_ack, input logic [7:0] exp, input string tag);
    logic [7:0] b;
    sda_host = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait(); scl = 1'b1; qwait(); b[i] = sda_line; qwait(); scl = 1'b0;
    end
    exp_q.push_back(exp); tag_q.push_back(tag); act_q.push_back(b);
    sda_host = ~give_ack; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    sda_host = 1'b1;
  endtask

  task automatic check_regs(input string req);
    repeat (4) @(negedge clk);
    for (int k = 0; k < N; k++)
      check(cfg_regs[8*k +: 8] == model[k], req, cfg_regs[8*k +: 8], model[k]);
  endtask

  task automatic write_block(input int n, input logic [7:0] base, input string req);
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); check(ack, "R1 write address ack", ack, 1);
    send_byte(8'hA5, ack); check(ack, "R2 command ack", ack, 1);
    send_byte(8'h3C, ack); check(ack, "R2 count ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i * 17), ack);
      check(ack, (i < N) ? "R3 data ack" : "R9 overflow ack", ack, 1);
      if (i < N) model[i] = base + 8'(i * 17);
    end
    bus_stop();
    check_regs(req);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R7: defaults
    model[0] = 8'h0C;
    for (int k = 1; k < N; k++) model[k] = 8'hFF;
    check(!sda_drive_low, "R7 sda released after reset", sda_drive_low, 0);
    check_regs("R7 reset defaults");

    // R2 R3: full write, header bytes non-zero and discarded
    write_block(6, 8'h11, "R3 full write");
    // R4: stop after two data bytes
    write_block(2, 8'h80, "R4 partial write");
    // R9: eight data bytes, last two dropped
    write_block(8, 8'h05, "R9 overflow write");

    // R5: foreign address NACKed, later byte ignored
    bus_start();
    send_byte(8'hA0, ack); check(!ack, "R5 foreign address nack", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R5 idle after nack", ack, 0);
    bus_stop();
    check_regs("R5 registers untouched");

    // R6: full read
    bus_start();
    send_byte(8'hD3, ack); check(ack, "R1 read address ack", ack, 1);
    recv_byte(1'b1, 8'h06, "R6 count byte");
    for (int k = 0; k < N; k++) recv_byte(k != N - 1, model[k], "R6 register byte");
    check(!sda_drive_low, "R8 released after final nack", sda_drive_low, 0);
    bus_stop();

    // R8 R10: early NACK, then repeated start into a write
    bus_start();
    send_byte(8'hD3, ack); check(ack, "R1 read address ack", ack, 1);
    recv_byte(1'b1, 8'h06, "R6 count byte");
    recv_byte(1'b0, model[0], "R8 byte before nack");
    qwait();
    check(!sda_drive_low, "R8 sda released after nack", sda_drive_low, 0);
    write_block(1, 8'h42, "R10 repeated start write");

    // R10: start in the middle of a byte aborts it
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    for (int i = 7; i >= 4; i--) begin
      sda_host = 1'b0; qwait(); scl = 1'b1; qwait(); qwait(); scl = 1'b0; qwait();
    end
    write_block(1, 8'h99, "R10 aborted byte not stored");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule